// File: doc/BRIEF.md
# Configurable Packet CRC Checker

This block watches a byte stream of received packets and checks a 32-bit CRC over a window of each packet. The stream carries one byte per cycle, with a valid qualifier and markers for the first and last byte. Configuration inputs set the following:
- two generator polynomials and a bit that selects one of them;
- where the checked window starts and ends;
- where the packet carries its CRC field;
- whether input bytes are bit-reversed;
- whether the computed CRC is inverted before the compare;
- a mode that ends the window one byte before the packet ends.

When the CRC field lies inside the checked window, its bytes enter the CRC as zero. This lets the checker cover a region that holds its own check value. On the cycle after the last byte, the block raises a one-cycle strobe. With that strobe it presents the CRC compare result and one receive-descriptor status bit. That bit carries either the CRC result or a checksum status supplied from outside.

Top module: `pkt_crc_checker`

## Requirements
- R1: The CRC is 32 bits wide and starts from all ones at each packet. It is updated once per covered byte, MSB first: the byte is XORed into bits 31..24, then 8 shift-left steps are applied, each XORing in the polynomial when the bit shifted out is 1. A packet passes when the final value equals the received CRC.
- R2: `cfg_poly_sel` = 0 uses `cfg_poly0` and `cfg_poly_sel` = 1 uses `cfg_poly1`.
- R3: Bytes are indexed from 0, the start-of-packet byte being index 0. Bytes with an index below `cfg_start_ofs` are not covered.
- R4: When `cfg_fcoe` = 0, covered bytes run from `cfg_start_ofs` to `cfg_end_ofs` inclusive. Later bytes have no effect on the result.
- R5: When `cfg_fcoe` = 1, coverage runs from `cfg_start_ofs` up to the byte before the end-of-packet byte. `cfg_end_ofs` is ignored, and the last byte has no effect on the result.
- R6: The received CRC is the bytes at indices `cfg_crc_pos` to `cfg_crc_pos`+3, with the first of them most significant. It starts at zero for each packet. Field bytes that are covered are fed into the CRC as 0x00.
- R7: When `cfg_mirror` = 1, bit k of each fed byte is moved to bit 7-k before the update.
- R8: When `cfg_invert` = 1, the final CRC is bitwise inverted before the compare.
- R9: `status_strobe` is high for exactly the cycle after an accepted end-of-packet byte. `crc_pass` and `desc_bit2` update only on that strobe and hold otherwise.
- R10: On the strobe, `desc_bit2` equals `crc_pass` when `cfg_use_crc` = 1. When `cfg_use_crc` = 0 it equals `tcp_csum_ok` sampled with the end-of-packet byte.
- R11: All configuration inputs are taken with the start-of-packet byte. Changes to them later in the packet have no effect.
- R12: The block ignores cycles with `in_valid` = 0, and valid bytes that arrive outside a packet (no start-of-packet since the last end-of-packet). Neither kind produces a strobe.
- R13: Synchronous active-high `rst` clears `status_strobe`, `crc_pass` and `desc_bit2` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_data | input | 8 | Packet byte |
| cfg_poly0 | input | 32 | Polynomial 0 |
| cfg_poly1 | input | 32 | Polynomial 1 |
| cfg_poly_sel | input | 1 | Polynomial select |
| cfg_start_ofs | input | 8 | First covered byte index |
| cfg_end_ofs | input | 16 | Last covered byte index (non-FCoE) |
| cfg_crc_pos | input | 16 | Index of first CRC field byte |
| cfg_mirror | input | 1 | Reverse bits in each byte |
| cfg_invert | input | 1 | Invert final CRC |
| cfg_fcoe | input | 1 | End coverage before last byte |
| cfg_use_crc | input | 1 | Descriptor bit carries CRC result |
| tcp_csum_ok | input | 1 | External checksum status |
| status_strobe | output | 1 | Result valid, one cycle |
| crc_pass | output | 1 | CRC compare result |
| desc_bit2 | output | 1 | Descriptor status bit 2 |

## Verification
All three results come from one register stage. They are due at the first clock edge after the end-of-packet byte is accepted. The bench drives each byte on a falling edge and samples at the following falling edge, which is the cycle the strobe is expected. It then samples once more to confirm that the strobe has dropped and the results hold. Idle cycles and stray bytes are checked on the same one-cycle schedule, where the expected strobe is 0.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;
  localparam int STRT_W = 8;
  localparam int IDX_W  = 16;
  localparam int FLD_N  = CRC_W / BYTE_W;

  typedef struct packed {
    logic [CRC_W-1:0]  poly0;
    logic [CRC_W-1:0]  poly1;
    logic              poly_sel;
    logic [STRT_W-1:0] start_ofs;
    logic [IDX_W-1:0]  end_ofs;
    logic [IDX_W-1:0]  crc_pos;
    logic              mirror;
    logic              invert;
    logic              fcoe;
    logic              use_crc;
  } chk_cfg_t;

  function automatic logic [BYTE_W-1:0] flip_bits(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int k = 0; k < BYTE_W; k++) r[k] = b[BYTE_W-1-k];
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] b,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = c ^ {b, {(CRC_W-BYTE_W){1'b0}}};
    for (int k = 0; k < BYTE_W; k++)
      r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/crc_cfg_hold.sv
module crc_cfg_hold
  import crc_chk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sop_take,
  input  chk_cfg_t live_cfg,
  output chk_cfg_t eff_cfg
);
  chk_cfg_t held_q;

  always_ff @(posedge clk) begin
    if (rst)           held_q <= '0;
    else if (sop_take) held_q <= live_cfg;
  end

  assign eff_cfg = sop_take ? live_cfg : held_q;
endmodule

// File: rtl/crc_byte_tracker.sv
module crc_byte_tracker
  import crc_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [STRT_W-1:0] start_ofs,
  input  logic [IDX_W-1:0]  end_ofs,
  input  logic [IDX_W-1:0]  crc_pos,
  input  logic              mirror,
  input  logic              fcoe,
  output logic              beat_ok,
  output logic              beat_eop,
  output logic              pkt_open,
  output logic              cov_hit,
  output logic              field_hit,
  output logic [BYTE_W-1:0] feed_byte,
  output logic [IDX_W-1:0]  byte_cnt
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] cnt_q;
  logic             open_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   idx_x, pos_x;
  logic             past_end;
  logic [BYTE_W-1:0] masked;

  assign beat_ok  = in_valid && (in_sop || open_q);
  assign beat_eop = beat_ok && in_eop;
  assign idx      = in_sop ? '0 : cnt_q;
  assign idx_x    = {1'b0, idx};
  assign pos_x    = {1'b0, crc_pos};

  assign field_hit = (idx_x >= pos_x) && (idx_x < pos_x + (IDX_W+1)'(FLD_N));
  assign past_end  = fcoe ? in_eop : (idx > end_ofs);
  assign cov_hit   = beat_ok && (idx >= IDX_W'(start_ofs)) && !past_end;

  assign masked    = field_hit ? '0 : in_data;
  assign feed_byte = mirror ? flip_bits(masked) : masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (beat_ok) begin
      cnt_q  <= (idx == IDX_MAX) ? idx : idx + 1'b1;
      open_q <= !in_eop;
    end
  end

  assign pkt_open = open_q;
  assign byte_cnt = cnt_q;
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_ok,
  input  logic              in_sop,
  input  logic              cov_hit,
  input  logic              field_hit,
  input  logic [BYTE_W-1:0] feed_byte,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [CRC_W-1:0]  poly,
  output logic [CRC_W-1:0]  crc_next,
  output logic [CRC_W-1:0]  rx_next,
  output logic [CRC_W-1:0]  crc_state
);
  logic [CRC_W-1:0] crc_q, rx_q, crc_base, rx_base;

  assign crc_base = in_sop ? '1 : crc_q;
  assign rx_base  = in_sop ? '0 : rx_q;
  assign crc_next = cov_hit ? crc_step(crc_base, feed_byte, poly) : crc_base;
  assign rx_next  = field_hit ? {rx_base[CRC_W-BYTE_W-1:0], in_data} : rx_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '1;
      rx_q  <= '0;
    end else if (beat_ok) begin
      crc_q <= crc_next;
      rx_q  <= rx_next;
    end
  end

  assign crc_state = crc_q;
endmodule

// File: rtl/pkt_crc_checker.sv
module pkt_crc_checker
  import crc_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  input  logic [31:0]       cfg_poly0,
  input  logic [31:0]       cfg_poly1,
  input  logic              cfg_poly_sel,
  input  logic [7:0]        cfg_start_ofs,
  input  logic [15:0]       cfg_end_ofs,
  input  logic [15:0]       cfg_crc_pos,
  input  logic              cfg_mirror,
  input  logic              cfg_invert,
  input  logic              cfg_fcoe,
  input  logic              cfg_use_crc,
  input  logic              tcp_csum_ok,
  output logic              status_strobe,
  output logic              crc_pass,
  output logic              desc_bit2
);
  chk_cfg_t live_cfg, eff_cfg;
  logic beat_ok, beat_eop, pkt_open, cov_hit, field_hit, sop_take;
  logic [BYTE_W-1:0] feed_byte;
  logic [IDX_W-1:0]  byte_cnt;
  logic [CRC_W-1:0]  crc_next, rx_next, crc_state, crc_final, sel_poly;
  logic eff_use_crc, match_now;

  assign live_cfg = '{poly0: cfg_poly0, poly1: cfg_poly1, poly_sel: cfg_poly_sel,
                      start_ofs: cfg_start_ofs, end_ofs: cfg_end_ofs,
                      crc_pos: cfg_crc_pos, mirror: cfg_mirror, invert: cfg_invert,
                      fcoe: cfg_fcoe, use_crc: cfg_use_crc};
  assign sop_take = in_valid && in_sop;

  crc_cfg_hold u_cfg (
    .clk(clk), .rst(rst), .sop_take(sop_take), .live_cfg(live_cfg), .eff_cfg(eff_cfg)
  );

  crc_byte_tracker u_trk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .start_ofs(eff_cfg.start_ofs), .end_ofs(eff_cfg.end_ofs),
    .crc_pos(eff_cfg.crc_pos), .mirror(eff_cfg.mirror), .fcoe(eff_cfg.fcoe),
    .beat_ok(beat_ok), .beat_eop(beat_eop), .pkt_open(pkt_open), .cov_hit(cov_hit),
    .field_hit(field_hit), .feed_byte(feed_byte), .byte_cnt(byte_cnt)
  );

  assign sel_poly = eff_cfg.poly_sel ? eff_cfg.poly1 : eff_cfg.poly0;

  crc_engine u_eng (
    .clk(clk), .rst(rst), .beat_ok(beat_ok), .in_sop(in_sop), .cov_hit(cov_hit),
    .field_hit(field_hit), .feed_byte(feed_byte), .in_data(in_data), .poly(sel_poly),
    .crc_next(crc_next), .rx_next(rx_next), .crc_state(crc_state)
  );

  assign crc_final   = eff_cfg.invert ? ~crc_next : crc_next;
  assign match_now   = (crc_final == rx_next);
  assign eff_use_crc = eff_cfg.use_crc;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_strobe <= 1'b0;
      crc_pass      <= 1'b0;
      desc_bit2     <= 1'b0;
    end else begin
      status_strobe <= beat_eop;
      if (beat_eop) begin
        crc_pass  <= match_now;
        desc_bit2 <= eff_use_crc ? match_now : tcp_csum_ok;
      end
    end
  end
endmodule

// File: rtl/pkt_crc_checker_chk.sv
module pkt_crc_checker_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_sop,
  input logic        beat_ok,
  input logic        beat_eop,
  input logic        pkt_open,
  input logic        eff_use_crc,
  input logic        tcp_csum_ok,
  input logic [31:0] crc_state,
  input logic [15:0] byte_cnt,
  input logic        status_strobe,
  input logic        crc_pass,
  input logic        desc_bit2
);
  p_strobe_after_eop_r9: assert property (@(posedge clk) disable iff (rst)
    beat_eop |=> status_strobe);

  p_no_spurious_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !beat_eop |=> !status_strobe);

  p_results_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !status_strobe |-> $stable(crc_pass) && $stable(desc_bit2));

  p_desc_from_crc_r10: assert property (@(posedge clk) disable iff (rst)
    beat_eop && eff_use_crc |=> desc_bit2 == crc_pass);

  p_desc_from_tcp_r10: assert property (@(posedge clk) disable iff (rst)
    beat_eop && !eff_use_crc && tcp_csum_ok |=> desc_bit2);

  p_stray_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_sop && !pkt_open |=> $stable(crc_state) && $stable(byte_cnt));

  p_sop_restarts_count_r3: assert property (@(posedge clk) disable iff (rst)
    beat_ok && in_sop |=> byte_cnt == 16'd1);

  p_reset_clears_r13: assert property (@(posedge clk)
    $past(rst) |-> !status_strobe && !crc_pass && !desc_bit2);
endmodule

bind pkt_crc_checker pkt_crc_checker_chk u_pkt_crc_checker_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .beat_ok(beat_ok),
  .beat_eop(beat_eop), .pkt_open(pkt_open), .eff_use_crc(eff_use_crc),
  .tcp_csum_ok(tcp_csum_ok), .crc_state(crc_state), .byte_cnt(byte_cnt),
  .status_strobe(status_strobe), .crc_pass(crc_pass), .desc_bit2(desc_bit2)
);

// File: tb/test_pkt_crc_checker.sv
module test_pkt_crc_checker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = '0;
  logic [31:0] p_poly0 = '0, p_poly1 = '0;
  logic p_sel = 0, p_mir = 0, p_inv = 0, p_fcoe = 0, p_use = 0, p_tcp = 0;
  logic [7:0] p_start = '0;
  logic [15:0] p_end = '0, p_pos = '0;
  logic status_strobe, crc_pass, desc_bit2;

  // configuration the expected values are computed from
  logic [31:0] s_poly0, s_poly1;
  logic s_sel, s_mir, s_inv, s_fcoe, s_use, s_tcp;
  logic [7:0] s_start;
  logic [15:0] s_end, s_pos;
  logic [7:0] pkt [0:63];

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  pkt_crc_checker i_pkt_crc_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .cfg_poly0(p_poly0), .cfg_poly1(p_poly1), .cfg_poly_sel(p_sel),
    .cfg_start_ofs(p_start), .cfg_end_ofs(p_end), .cfg_crc_pos(p_pos),
    .cfg_mirror(p_mir), .cfg_invert(p_inv), .cfg_fcoe(p_fcoe), .cfg_use_crc(p_use),
    .tcp_csum_ok(p_tcp), .status_strobe(status_strobe), .crc_pass(crc_pass),
    .desc_bit2(desc_bit2)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic bit covered(int i, int len);
    if (i < int'(s_start)) return 0;
    if (s_fcoe) return i != len - 1;
    return i <= int'(s_end);
  endfunction

  function automatic bit in_fld(int i);
    return i >= int'(s_pos) && i < int'(s_pos) + 4;
  endfunction

  // bit-serial restatement of the CRC update
  function automatic logic [31:0] ref_final(int len);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] poly = s_sel ? s_poly1 : s_poly0;
    for (int i = 0; i < len; i++) begin
      if (covered(i, len)) begin
        logic [7:0] b = in_fld(i) ? 8'h00 : pkt[i];
        for (int j = 7; j >= 0; j--) begin
          logic in_bit = s_mir ? b[7-j] : b[j];
          logic fb = c[31] ^ in_bit;
          c = {c[30:0], 1'b0};
          if (fb) c = c ^ poly;
        end
      end
    end
    return s_inv ? ~c : c;
  endfunction

  function automatic logic [31:0] ref_rx(int len);
    logic [31:0] r = '0;
    for (int i = 0; i < len; i++)
      if (in_fld(i)) r = {r[23:0], pkt[i]};
    return r;
  endfunction

  task automatic make_good(int len);
    logic [31:0] f = ref_final(len);
    for (int k = 0; k < 4; k++)
      if (int'(s_pos) + k < len) pkt[int'(s_pos) + k] = f[31-8*k -: 8];
  endtask

  task automatic fill(int len);
    for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
  endtask

  task automatic base_cfg();
    s_poly0 = 32'h04C1_1DB7; s_poly1 = 32'h1EDC_6F41; s_sel = 0;
    s_mir = 0; s_inv = 0; s_fcoe = 0; s_use = 1; s_tcp = 0;
    s_start = 0; s_end = 16'hFFFF; s_pos = 16'd60;
  endtask

  task automatic drive_cfg();
    p_poly0 = s_poly0; p_poly1 = s_poly1; p_sel = s_sel; p_mir = s_mir; p_inv = s_inv;
    p_fcoe = s_fcoe; p_use = s_use; p_tcp = s_tcp; p_start = s_start; p_end = s_end;
    p_pos = s_pos;
  endtask

  task automatic scramble_cfg();
    p_poly0 = $urandom; p_poly1 = $urandom; p_sel = 1'($urandom); p_mir = 1'($urandom);
    p_inv = 1'($urandom); p_fcoe = 1'($urandom); p_use = 1'($urandom);
    p_start = 8'($urandom); p_end = 16'($urandom % 64); p_pos = 16'($urandom % 64);
  endtask

  task automatic send_pkt(int len, string tag, bit twiddle, bit gaps, bit strays);
    bit exp_pass = (ref_final(len) == ref_rx(len));
    bit exp_desc = s_use ? exp_pass : s_tcp;
    logic held;
    for (int i = 0; i < len; i++) begin
      if (gaps && i > 0 && ($urandom % 3 == 0)) begin
        @(negedge clk);
        in_valid = 0; in_sop = 1'($urandom); in_eop = 1'($urandom); in_data = 8'($urandom);
      end
      @(negedge clk);
      if (i == 0) drive_cfg();
      if (i == 1 && twiddle) scramble_cfg();
      in_valid = 1; in_sop = (i == 0); in_eop = (i == len - 1); in_data = pkt[i];
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    chk({tag, " strobe (R9)"}, 32'(status_strobe), 1);
    chk({tag, " crc_pass"}, 32'(crc_pass), 32'(exp_pass));
    chk({tag, " desc_bit2 (R10)"}, 32'(desc_bit2), 32'(exp_desc));
    held = crc_pass;
    @(negedge clk);
    chk("R9 strobe drops", 32'(status_strobe), 0);
    chk("R9 crc_pass holds", 32'(crc_pass), 32'(held));
    drive_cfg();
    if (strays) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        in_valid = 1; in_sop = 0; in_eop = 1'($urandom); in_data = 8'($urandom);
        @(negedge clk);
        in_valid = 0; in_eop = 0;
        chk("R12 stray byte no strobe", 32'(status_strobe), 0);
        chk("R12 stray byte result held", 32'(crc_pass), 32'(held));
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    base_cfg(); drive_cfg();
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R13 strobe after reset", 32'(status_strobe), 0);
    chk("R13 crc_pass after reset", 32'(crc_pass), 0);
    chk("R13 desc_bit2 after reset", 32'(desc_bit2), 0);

    // R1: plain check, good then corrupted
    base_cfg(); s_pos = 36; s_end = 35; fill(40); make_good(40);
    send_pkt(40, "R1 good", 0, 0, 0);
    chk("R1 model pass", 32'(ref_final(40) == ref_rx(40)), 1);
    pkt[10] ^= 8'h5A; send_pkt(40, "R1 corrupt", 0, 0, 0);

    // R2: second polynomial, and a mismatch when the selection flips
    base_cfg(); s_sel = 1; s_pos = 20; s_end = 19; fill(24); make_good(24);
    send_pkt(24, "R2 poly1", 0, 0, 0);
    s_sel = 0; send_pkt(24, "R2 poly0 mismatch", 0, 0, 0);

    // R3: bytes before the start offset do not matter
    base_cfg(); s_start = 6; s_pos = 30; s_end = 29; fill(34); make_good(34);
    pkt[2] ^= 8'hFF; send_pkt(34, "R3 before start", 0, 0, 0);

    // R4: bytes past the end offset do not matter
    base_cfg(); s_end = 20; s_pos = 30; fill(40); make_good(40);
    pkt[25] ^= 8'h3C; send_pkt(40, "R4 past end", 0, 0, 0);

    // R5: end offset ignored, last byte excluded
    base_cfg(); s_fcoe = 1; s_end = 2; s_start = 3; s_pos = 10; fill(30); make_good(30);
    pkt[29] ^= 8'h81; send_pkt(30, "R5 last byte excluded", 0, 0, 0);
    pkt[20] ^= 8'h01; send_pkt(30, "R5 covered byte flip", 0, 0, 0);

    // R6: CRC field inside the covered window
    base_cfg(); s_pos = 8; s_end = 31; fill(32); make_good(32);
    send_pkt(32, "R6 field zeroed", 0, 0, 0);

    // R7: mirroring, and its mismatch when toggled
    base_cfg(); s_mir = 1; s_pos = 4; s_end = 27; fill(28); make_good(28);
    send_pkt(28, "R7 mirror", 0, 0, 0);
    s_mir = 0; send_pkt(28, "R7 mirror off", 0, 0, 0);

    // R8: final inversion
    base_cfg(); s_inv = 1; s_pos = 12; s_end = 16; fill(20); make_good(20);
    send_pkt(20, "R8 invert", 0, 0, 0);
    s_inv = 0; send_pkt(20, "R8 invert off", 0, 0, 0);

    // R10: external checksum status selected
    base_cfg(); s_use = 0; s_tcp = 1; fill(16); send_pkt(16, "R10 tcp status", 0, 0, 0);

    // R11: config changes after start of packet
    base_cfg(); s_pos = 40; s_end = 50; s_start = 2; fill(48); make_good(48);
    send_pkt(48, "R11 cfg scrambled", 1, 0, 0);

    // R12: idle gaps and stray bytes
    base_cfg(); s_pos = 0; s_end = 17; fill(18); make_good(18);
    send_pkt(18, "R12 gaps", 0, 1, 1);

    // one-byte packet
    base_cfg(); fill(1); send_pkt(1, "R9 single byte", 0, 0, 0);

    for (int n = 0; n < 250; n++) begin
      int len = 1 + int'($urandom % 64);
      base_cfg();
      s_poly0 = $urandom | 32'h1; s_poly1 = $urandom | 32'h1; s_sel = 1'($urandom);
      s_mir = 1'($urandom); s_inv = 1'($urandom); s_fcoe = 1'($urandom);
      s_use = 1'($urandom); s_tcp = 1'($urandom);
      s_start = 8'($urandom % (len + 2)); s_end = 16'($urandom % 70);
      s_pos = 16'($urandom % (len + 2));
      fill(len);
      if ($urandom % 4 != 0) make_good(len);
      if ($urandom % 5 == 0) pkt[$urandom % len] ^= 8'h10;
      send_pkt(len, "R1 random", 1'($urandom), 1'($urandom), ($urandom % 4 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule